// File: doc/BRIEF.md
# BCD Calendar Counter With Century

This block holds wall-clock time and the calendar date as eight packed-BCD bytes: seconds, minutes, hours in 24-hour form, a weekday number, the day of the month, the month, a two-digit year and a two-digit century. A one-second strobe advances the seconds. A carry then ripples upward through the fields in the same clock edge. The block applies each month's length and the four-year leap rule, so the calendar stays correct without help from software.

A load strobe replaces all eight fields at once with values presented in parallel. The current fields are always visible on parallel outputs. A run-enable input freezes the count without losing the stored values. This lets a surrounding register interface hold the time steady while it is being set.

Top module: `bcd_timekeeper`

## Requirements
- R1: Seconds and minutes count 00 to 59 and hours count 00 to 23. Each wrap to 00 carries one into the next field up.
- R2: The weekday field takes values 01 to 07. It advances by one at each midnight rollover (23:59:59 to 00:00:00), and 07 is followed by 01.
- R3: The day of the month runs from 01 to the last day of the current month, then returns to 01 and carries into the month. The month runs 01 to 12, then returns to 01 and carries into the year.
- R4: Months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31.
- R5: Month 02 ends after day 29 when the two-digit year value is a multiple of 4, and after day 28 otherwise.
- R6: The year runs 00 to 99. When it wraps from 99 to 00, the century increments in BCD, and century 39 is followed by 00.
- R7: Every field is packed BCD: bits 7:4 hold the tens digit and bits 3:0 hold the units digit. An increment from units 9 clears the units and raises the tens (for example 09 becomes 10).
- R8: When load is 1 at a clock edge, all eight fields take the load inputs at that edge. This has priority over a one-second strobe in the same cycle.
- R9: When run_en is 0, or tick is 0, no field changes, unless load is 1.
- R10: After reset, time reads 00:00:00, weekday 01, day 01, month 01, year 00 and century 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enabled when 1 |
| tick | input | 1 | One-second strobe, one clock wide |
| load | input | 1 | Parallel load of all fields |
| ld_sec | input | 8 | Seconds to load (BCD) |
| ld_min | input | 8 | Minutes to load (BCD) |
| ld_hour | input | 8 | Hours to load (BCD) |
| ld_wday | input | 8 | Weekday to load (BCD 01-07) |
| ld_mday | input | 8 | Day of month to load (BCD) |
| ld_mon | input | 8 | Month to load (BCD) |
| ld_year | input | 8 | Year to load (BCD) |
| ld_cent | input | 8 | Century to load (BCD 00-39) |
| sec_o | output | 8 | Current seconds |
| min_o | output | 8 | Current minutes |
| hour_o | output | 8 | Current hours |
| wday_o | output | 8 | Current weekday |
| mday_o | output | 8 | Current day of month |
| mon_o | output | 8 | Current month |
| year_o | output | 8 | Current year |
| cent_o | output | 8 | Current century |

## Verification
The range and digit assertions assume that every load presents a legal calendar value: valid BCD digits, each field within its range, and a day that exists in the loaded month and year. An illegal load would break them at once. The bench therefore only ever loads values built from integers inside those ranges, including each month's true last day for every year from 00 to 99. It also sweeps a full day tick by tick and all forty centuries at year rollover, comparing each result with an arithmetic calendar model.

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
  parameter logic [7:0] CENT_LAST = 8'h39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_mday,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_cent,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] last_day;

  wire step    = tick & run_en & ~load;
  wire sec_top = sec_o == 8'h59;
  wire min_top = min_o == 8'h59;
  wire hr_top  = hour_o == 8'h23;
  wire mon_top = mon_o == 8'h12;
  wire yr_top  = year_o == 8'h99;

  wire leap = year_o[4] ? (year_o[3:0] == 4'd2 || year_o[3:0] == 4'd6)
                        : (year_o[3:0] == 4'd0 || year_o[3:0] == 4'd4 || year_o[3:0] == 4'd8);

  always_comb begin
    case (mon_o)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  wire c_min  = step & sec_top;
  wire c_hour = c_min & min_top;
  wire c_day  = c_hour & hr_top;
  wire c_mon  = c_day & (mday_o >= last_day);
  wire c_year = c_mon & mon_top;
  wire c_cent = c_year & yr_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_o  <= 8'h00;
      min_o  <= 8'h00;
      hour_o <= 8'h00;
      wday_o <= 8'h01;
      mday_o <= 8'h01;
      mon_o  <= 8'h01;
      year_o <= 8'h00;
      cent_o <= 8'h00;
    end else if (load) begin
      sec_o  <= ld_sec;
      min_o  <= ld_min;
      hour_o <= ld_hour;
      wday_o <= ld_wday;
      mday_o <= ld_mday;
      mon_o  <= ld_mon;
      year_o <= ld_year;
      cent_o <= ld_cent;
    end else begin
      if (step)   sec_o  <= sec_top ? 8'h00 : bcd_inc(sec_o);
      if (c_min)  min_o  <= min_top ? 8'h00 : bcd_inc(min_o);
      if (c_hour) hour_o <= hr_top ? 8'h00 : bcd_inc(hour_o);
      if (c_day)  wday_o <= (wday_o == 8'h07) ? 8'h01 : bcd_inc(wday_o);
      if (c_day)  mday_o <= (mday_o >= last_day) ? 8'h01 : bcd_inc(mday_o);
      if (c_mon)  mon_o  <= mon_top ? 8'h01 : bcd_inc(mon_o);
      if (c_year) year_o <= yr_top ? 8'h00 : bcd_inc(year_o);
      if (c_cent) cent_o <= (cent_o == CENT_LAST) ? 8'h00 : bcd_inc(cent_o);
    end
  end

endmodule

// File: rtl/bcd_timekeeper_chk.sv
module bcd_timekeeper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic       tick,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_min,
  input logic [7:0] ld_hour,
  input logic [7:0] ld_wday,
  input logic [7:0] ld_mday,
  input logic [7:0] ld_mon,
  input logic [7:0] ld_year,
  input logic [7:0] ld_cent,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] mday_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o,
  input logic [7:0] cent_o
);

  p_time_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o <= 8'h59 && min_o <= 8'h59 && hour_o <= 8'h23);

  p_digits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o[3:0] <= 4'd9 && min_o[3:0] <= 4'd9 && hour_o[3:0] <= 4'd9 &&
    mday_o[3:0] <= 4'd9 && mon_o[3:0] <= 4'd9 && year_o[3:0] <= 4'd9 &&
    year_o[7:4] <= 4'd9 && cent_o[3:0] <= 4'd9);

  p_wday_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wday_o >= 8'h01 && wday_o <= 8'h07);

  p_wday_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_en && !load && sec_o == 8'h59 && min_o == 8'h59 &&
     hour_o == 8'h23 && wday_o == 8'h07) |=> wday_o == 8'h01);

  p_cal_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mday_o >= 8'h01 && mday_o <= 8'h31 && mon_o >= 8'h01 && mon_o <= 8'h12);

  p_short_month_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_o == 8'h04 || mon_o == 8'h06 || mon_o == 8'h09 || mon_o == 8'h11) |-> mday_o <= 8'h30);

  p_feb_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mon_o == 8'h02 |-> mday_o <= 8'h29);

  p_cent_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cent_o <= 8'h39);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sec_o == $past(ld_sec) && min_o == $past(ld_min) && hour_o == $past(ld_hour) &&
             wday_o == $past(ld_wday) && mday_o == $past(ld_mday) && mon_o == $past(ld_mon) &&
             year_o == $past(ld_year) && cent_o == $past(ld_cent));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && run_en)) |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o) && $stable(cent_o));

endmodule

bind bcd_timekeeper bcd_timekeeper_chk u_chk (.*);

// File: tb/sim_bcd_timekeeper.sv
module sim_bcd_timekeeper;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic tick = 1'b0;
  logic load = 1'b0;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_wday = '0;
  logic [7:0] ld_mday = '0, ld_mon = '0, ld_year = '0, ld_cent = '0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o, cent_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_sec, m_min, m_hr, m_wd, m_md, m_mon, m_yr, m_cen;

  always #(CLK_P / 2) clk = ~clk;

  bcd_timekeeper u0 (
    .clk, .rst_n, .run_en, .tick, .load,
    .ld_sec, .ld_min, .ld_hour, .ld_wday, .ld_mday, .ld_mon, .ld_year, .ld_cent,
    .sec_o, .min_o, .hour_o, .wday_o, .mday_o, .mon_o, .year_o, .cent_o
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_wd = (m_wd == 7) ? 1 : m_wd + 1;
          m_md++;
          if (m_md > mdays(m_mon, m_yr)) begin
            m_md = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_yr++;
              if (m_yr == 100) begin
                m_yr = 0;
                m_cen = (m_cen == 39) ? 0 : m_cen + 1;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic check_all(input string req);
    logic [63:0] got, exp;
    got = {cent_o, year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};
    exp = {bcd(m_cen), bcd(m_yr), bcd(m_mon), bcd(m_md), bcd(m_wd), bcd(m_hr), bcd(m_min), bcd(m_sec)};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_model(input int s, input int mi, input int h, input int w,
                           input int d, input int mo, input int y, input int c);
    m_sec = s; m_min = mi; m_hr = h; m_wd = w; m_md = d; m_mon = mo; m_yr = y; m_cen = c;
  endtask

  task automatic do_load(input int s, input int mi, input int h, input int w,
                         input int d, input int mo, input int y, input int c);
    ld_sec = bcd(s); ld_min = bcd(mi); ld_hour = bcd(h); ld_wday = bcd(w);
    ld_mday = bcd(d); ld_mon = bcd(mo); ld_year = bcd(y); ld_cent = bcd(c);
    load = 1'b1; tick = 1'b0;
    cyc();
    load = 1'b0;
    set_model(s, mi, h, w, d, mo, y, c);
  endtask

  task automatic one_tick(input string req);
    run_en = 1'b1; tick = 1'b1;
    cyc();
    tick = 1'b0;
    model_tick();
    check_all(req);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    set_model(0, 0, 0, 1, 1, 1, 0, 0);
    check_all("R10 reset state");

    // R1 R7: one full day tick by tick, crossing Feb 28 -> Mar 1 of a common year
    do_load(0, 0, 0, 3, 28, 2, 23, 20);
    run_en = 1'b1; tick = 1'b1;
    for (int i = 0; i < 86400; i++) begin
      cyc();
      model_tick();
      check_all("R1 R7 day sweep");
    end
    tick = 1'b0;

    // R3 R4 R5: last day of every month of every year, and Feb 28 in every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        do_load(59, 59, 23, (m % 7) + 1, mdays(m, y), m, y, 20);
        one_tick("R3 R4 R5 month end");
      end
      do_load(59, 59, 23, 2, 28, 2, y, 20);
      one_tick("R5 Feb 28 rollover");
    end

    // R6: year 99 -> 00 for every century including the 39 -> 00 wrap
    for (int c = 0; c < 40; c++) begin
      do_load(59, 59, 23, 5, 31, 12, 99, c);
      one_tick("R6 century carry");
    end

    // R2: midnight from every weekday
    for (int w = 1; w <= 7; w++) begin
      do_load(59, 59, 23, w, 10, 5, 42, 20);
      one_tick("R2 weekday wrap");
    end

    // R8: load in the same cycle as a tick wins
    do_load(58, 59, 23, 7, 31, 12, 99, 39);
    ld_sec = bcd(17); ld_min = bcd(45); ld_hour = bcd(9); ld_wday = bcd(4);
    ld_mday = bcd(29); ld_mon = bcd(2); ld_year = bcd(48); ld_cent = bcd(21);
    run_en = 1'b1; tick = 1'b1; load = 1'b1;
    cyc();
    load = 1'b0; tick = 1'b0;
    set_model(17, 45, 9, 4, 29, 2, 48, 21);
    check_all("R8 load priority");

    // R9: ticks with run_en low, and run_en high with no tick
    do_load(59, 59, 23, 7, 31, 12, 99, 39);
    run_en = 1'b0; tick = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cyc();
      check_all("R9 run disabled");
    end
    run_en = 1'b1; tick = 1'b0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      check_all("R9 no tick");
    end
    one_tick("R6 R2 full rollover after hold");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule